// File: doc/BRIEF.md
# Ethernet Frame to Typed-Word Packer

This block sits between a frame source and the transmit FIFO of a small network interface. A frame arrives one byte per handshake, with a last-byte marker. Two per-frame side inputs travel with the bytes: a trailer request and a 16-bit frame identifier. The block turns the frame into a stream of 18-bit words. Each word has a 2-bit type tag in bits 17:16 and a 16-bit payload in bits 15:0.

Each frame starts with a status word. The bytes follow, packed two per word. A frame shorter than 60 bytes is extended with zero bytes to 60. When the length is odd, the final byte goes out alone in a byte-select word. When a trailer is requested, two out-of-band words come last: a fixed marker, then the frame identifier. A one-cycle done pulse tells the source that the last word of the frame has been taken by the FIFO.

Both stream sides use valid/ready. The output side follows these rules:
- A word stays valid and unchanged until `out_ready` is high at a clock edge.
- `out_ready` low means the FIFO is full.
- While `out_ready` is low, the byte input is stalled (`in_ready` low).
- No word is lost or repeated.

On the input side, a byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_data`, `in_last`, `in_oob_req` and `in_frame_id` must stay stable while `in_valid` is high and `in_ready` is low.

Top module: `frame_word_packer`

## Requirements
- R1: Before the first byte of each frame, the block emits a status word: tag 2 (binary 10), payload 0x0000.
- R2: Bytes are packed two per word under tag 0. The earlier byte of a pair goes in bits 15:8 and the later byte in bits 7:0.
- R3: A frame of fewer than 60 bytes is extended with zero-valued bytes up to exactly 60 bytes before packing.
- R4: When the packed length is odd, the final byte is sent as a tag 3 word. The byte sits in bits 15:8 and bits 7:0 are zero.
- R5: When the packed length is even, the final byte pair goes out as an ordinary tag 0 word, and no tag 3 word is emitted.
- R6: If `in_oob_req` is high with a frame's first byte, two tag 1 words follow the data: first 0x1000, then the `in_frame_id` sampled with that first byte. Without the request, no tag 1 word is emitted.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` holds its value into the next cycle.
- R8: `in_ready` is low in every cycle where `out_ready` is low. Every byte is packed exactly once and in order, across any back-pressure pattern.
- R9: `frame_done` is high for exactly one cycle: the cycle after the frame's last word is accepted at the output. It is low at all other times.
- R10: After reset, `out_valid`, `frame_done` and `in_ready` are low until a frame's first byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Block takes the byte this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_oob_req | input | 1 | Request out-of-band trailer (sampled with first byte) |
| in_frame_id | input | 16 | Frame identifier for the trailer (sampled with first byte) |
| out_valid | output | 1 | Word present on `out_word` |
| out_ready | input | 1 | FIFO can take a word (low = full) |
| out_word | output | 18 | {type tag[1:0], payload[15:0]} |
| frame_done | output | 1 | One-cycle pulse after the last word of a frame is accepted |

## Verification
Some properties are checked by assertions on every cycle:
- The output holds under back-pressure.
- The input stalls whenever the FIFO is full.
- Status words always carry a zero payload.
- The low byte of byte-select words is always zero.
- The done pulse is a single cycle that follows an accepted word.

Other properties can only be shown by the bench's scenarios, by comparing whole word sequences against an independently built model. These are:
- the byte order within pairs;
- the exact padding count and zero fill;
- the choice between a byte-select and a data final word at the 59/60/61-byte edges;
- the order and content of the trailer words;
- the placement of the done pulse relative to each frame's real last word.

// File: rtl/pkr_pkg.sv
package pkr_pkg;
  typedef enum logic [1:0] {
    TAG_DATA   = 2'd0,
    TAG_OOB    = 2'd1,
    TAG_STATUS = 2'd2,
    TAG_BSEL   = 2'd3
  } tag_e;

  localparam logic [15:0] OOB_MARK = 16'h1000;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_HI,
    ST_LO,
    ST_BSEL,
    ST_OOB0,
    ST_OOB1
  } pk_state_e;
endpackage

// File: rtl/pkr_byte_src.sv
// Supplies the next frame byte: from the input, or a zero pad byte once the
// input frame ended early. Counts bytes and flags the final packed byte.
module pkr_byte_src #(
  parameter int MIN_LEN = 60,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          take,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          byte_avail,
  output logic [DW-1:0] byte_val,
  output logic          byte_last,
  output logic          padding
);
  localparam int CW = $clog2(MIN_LEN + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(MIN_LEN - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_LEN);

  logic          pad_q;
  logic [CW-1:0] cnt_q;

  assign padding = pad_q;

  always_comb begin
    byte_avail = pad_q | in_valid;
    byte_val   = pad_q ? '0 : in_data;
    byte_last  = pad_q ? (cnt_q == LAST_IDX) : (in_last && cnt_q >= LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      pad_q <= 1'b0;
      cnt_q <= '0;
    end else if (take) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (!pad_q && in_last && cnt_q < LAST_IDX) pad_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pkr_out_stage.sv
// Single output register with valid/ready and the frame-done pulse.
module pkr_out_stage #(
  parameter int WW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] ld_word,
  input  logic          ld_last,
  input  logic          out_ready,
  output logic          can_load,
  output logic          out_valid,
  output logic [WW-1:0] out_word,
  output logic          frame_done
);
  logic last_q;

  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_word   <= '0;
      last_q     <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= out_valid && out_ready && last_q;
      if (load && can_load) begin
        out_valid <= 1'b1;
        out_word  <= ld_word;
        last_q    <= ld_last;
      end else if (out_ready) begin
        out_valid <= 1'b0;
        last_q    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frame_word_packer.sv
module frame_word_packer #(
  parameter int MIN_LEN = 60,
  parameter int BW      = 8,
  parameter int IDW     = 16,
  parameter int TW      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BW-1:0]         in_data,
  input  logic                  in_last,
  input  logic                  in_oob_req,
  input  logic [IDW-1:0]        in_frame_id,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [TW+2*BW-1:0]    out_word,
  output logic                  frame_done
);
  import pkr_pkg::*;

  localparam int PW = 2 * BW;
  localparam int WW = TW + PW;

  pk_state_e     st_q, st_d;
  logic [BW-1:0] hold_q, hold_d;
  logic          oob_q, oob_d;
  logic [IDW-1:0] id_q, id_d;

  logic          start, take;
  logic          byte_avail, byte_last, padding;
  logic [BW-1:0] byte_val;
  logic          load, ld_last, can_load;
  logic [WW-1:0] ld_word;
  logic          src_ok;

  pkr_byte_src #(.MIN_LEN(MIN_LEN), .DW(BW)) u_src (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .byte_avail(byte_avail), .byte_val(byte_val), .byte_last(byte_last),
    .padding(padding)
  );

  pkr_out_stage #(.WW(WW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_word(ld_word), .ld_last(ld_last),
    .out_ready(out_ready), .can_load(can_load), .out_valid(out_valid),
    .out_word(out_word), .frame_done(frame_done)
  );

  // a pad byte never waits on the FIFO; a real byte does
  assign src_ok   = byte_avail && (padding || out_ready);
  assign in_ready = !padding && out_ready &&
                    ((st_q == ST_HI) || (st_q == ST_LO && can_load));

  always_comb begin
    st_d    = st_q;
    hold_d  = hold_q;
    oob_d   = oob_q;
    id_d    = id_q;
    start   = 1'b0;
    take    = 1'b0;
    load    = 1'b0;
    ld_last = 1'b0;
    ld_word = '0;
    case (st_q)
      ST_HDR: begin
        if (in_valid && can_load) begin
          load    = 1'b1;
          ld_word = {TAG_STATUS, {PW{1'b0}}};
          start   = 1'b1;
          oob_d   = in_oob_req;
          id_d    = in_frame_id;
          st_d    = ST_HI;
        end
      end
      ST_HI: begin
        if (src_ok) begin
          take   = 1'b1;
          hold_d = byte_val;
          st_d   = byte_last ? ST_BSEL : ST_LO;
        end
      end
      ST_LO: begin
        if (src_ok && can_load) begin
          take    = 1'b1;
          load    = 1'b1;
          ld_word = {TAG_DATA, hold_q, byte_val};
          if (byte_last) begin
            ld_last = !oob_q;
            st_d    = oob_q ? ST_OOB0 : ST_HDR;
          end else begin
            st_d = ST_HI;
          end
        end
      end
      ST_BSEL: begin
        if (can_load) begin
          load    = 1'b1;
          ld_word = {TAG_BSEL, hold_q, {BW{1'b0}}};
          ld_last = !oob_q;
          st_d    = oob_q ? ST_OOB0 : ST_HDR;
        end
      end
      ST_OOB0: begin
        if (can_load) begin
          load    = 1'b1;
          ld_word = {TAG_OOB, OOB_MARK};
          st_d    = ST_OOB1;
        end
      end
      ST_OOB1: begin
        if (can_load) begin
          load    = 1'b1;
          ld_word = {TAG_OOB, PW'(id_q)};
          ld_last = 1'b1;
          st_d    = ST_HDR;
        end
      end
      default: st_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      hold_q <= '0;
      oob_q  <= 1'b0;
      id_q   <= '0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
      oob_q  <= oob_d;
      id_q   <= id_d;
    end
  end
endmodule

// File: rtl/frame_word_packer_chk.sv
module frame_word_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [17:0] out_word,
  input logic        frame_done
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R7

  AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready); // R8

  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word[17:16] == 2'd2 |-> out_word[15:0] == 16'h0000); // R1

  AST_BSEL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word[17:16] == 2'd3 |-> out_word[7:0] == 8'h00); // R4

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(out_valid && out_ready)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R9
endmodule

bind frame_word_packer frame_word_packer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .frame_done(frame_done)
);

// File: tb/frame_word_packer_tb_top.sv
module frame_word_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_oob_req = 1'b0;
  logic [15:0] in_frame_id = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [17:0] out_word;
  logic        frame_done;

  int checks = 0, errors = 0;
  int stall_viol = 0;
  bit bp_mode = 1'b0;
  bit done_due = 1'b0;
  bit finished = 1'b0;
  string cur_req = "R2";
  logic [18:0] exp_q[$];

  always #5 clk = ~clk;

  frame_word_packer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_oob_req(in_oob_req),
    .in_frame_id(in_frame_id), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .frame_done(frame_done)
  );

  function automatic string tag_req(logic [1:0] t);
    case (t)
      2'd0: return "R2";
      2'd1: return "R6";
      2'd2: return "R1";
      default: return "R4";
    endcase
  endfunction

  // back-pressure generator
  always @(posedge clk) begin
    #1;
    if (bp_mode) out_ready = ($urandom % 3) != 0;
    else out_ready = 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!out_ready && in_ready) stall_viol++;
      if (done_due) begin
        checks++;
        if (frame_done !== 1'b1) begin
          errors++;
          $display("FAIL R9 frame_done actual=%b expected=1", frame_done);
        end
        done_due = 1'b0;
      end else if (frame_done) begin
        checks++; errors++;
        $display("FAIL R9 stray frame_done actual=1 expected=0");
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected word actual=%h expected=none", out_word);
        end else begin
          logic [18:0] e;
          e = exp_q.pop_front();
          if (out_word !== e[17:0]) begin
            errors++;
            $display("FAIL %s/%s word actual=%h expected=%h",
                     cur_req, tag_req(e[17:16]), out_word, e[17:0]);
          end
          if (e[18]) done_due = 1'b1;
        end
      end
    end
  end

  task automatic send(int len, bit oob, logic [15:0] id, int seed, string req);
    logic [7:0] b[];
    int n;
    bit acc;
    n = (len < 60) ? 60 : len;
    b = new[n];
    for (int i = 0; i < n; i++) b[i] = (i < len) ? 8'(seed + i * 7 + 1) : 8'h00;
    cur_req = req;
    exp_q.push_back({1'b0, 2'd2, 16'h0000});
    for (int i = 0; i + 1 < n; i += 2)
      exp_q.push_back({(!oob && i + 2 == n), 2'd0, b[i], b[i+1]});
    if (n % 2 == 1) exp_q.push_back({!oob, 2'd3, b[n-1], 8'h00});
    if (oob) begin
      exp_q.push_back({1'b0, 2'd1, 16'h1000});
      exp_q.push_back({1'b1, 2'd1, id});
    end
    in_oob_req  = oob;
    in_frame_id = id;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = b[i];
      in_last  = (i == len - 1);
      do begin
        @(negedge clk); acc = in_ready;
        @(posedge clk); #1;
      end while (!acc);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_oob_req  = 1'b0;
    in_frame_id = 16'hxxxx;
    while (exp_q.size() != 0 || done_due) begin
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || frame_done !== 1'b0 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset actual=%b%b%b expected=000", out_valid, frame_done, in_ready);
    end
    @(posedge clk); #1;
    send(1,  1'b0, 16'h0000, 3,  "R3");
    send(59, 1'b0, 16'h0000, 11, "R3");
    send(60, 1'b0, 16'h0000, 20, "R5");
    send(61, 1'b0, 16'h0000, 40, "R4");
    send(64, 1'b1, 16'hBEEF, 5,  "R6");
    send(75, 1'b1, 16'h1234, 9,  "R6");
    bp_mode = 1'b1;
    send(33, 1'b1, 16'h00A5, 2,  "R7");
    send(90, 1'b0, 16'h0000, 13, "R8");
    send(61, 1'b1, 16'h7F01, 17, "R8");
    bp_mode = 1'b0;
    repeat (3) @(posedge clk);
    checks++;
    if (stall_viol != 0) begin
      errors++;
      $display("FAIL R8 in_ready while full actual=%0d expected=0", stall_viol);
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 words missing actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule